// File: doc/BRIEF.md
# Vector Lane Compare and Branch Condition Unit

This block compares the X and Y lanes of two single-precision vectors. Each lane has its own operator. When a compare strobe arrives, the two results are captured into two condition flags. The flags then stay put until the next strobe, so later flow-control instructions can test them.

The same block produces one take-branch bit, which the sequencer uses to decide whether to branch. That bit comes from one of two sources:

- **Flag source.** Each flag is tested against its own reference bit. The two outcomes are merged by one of four combine modes.
- **Uniform source.** One entry of a small bank of boolean uniforms is read. Its sense can optionally be inverted; jump-on-uniform forms use this when the low bit of their count field is set.

The bank of uniforms is written one entry at a time through a simple write port.

Top module: `vcmp_cond_unit`

## Requirements
- R1: After reset, both flags `flag_x` and `flag_y` are 0 and every boolean uniform is 0.
- R2: On a cycle with `cmp_valid` high, `flag_x` takes, at the next clock edge, the result of comparing `a_x` with `b_x` under `op_x`. The operator codes are: 0 equal, 1 not-equal, 2 less-than, 3 less-or-equal, 4 greater-than, 5 greater-or-equal.
- R3: `flag_y` takes the result of `a_y` against `b_y` under `op_y`, using the same codes. This is independent of the X lane.
- R4: If either operand is NaN (exponent all ones, mantissa nonzero), codes 0, 2, 3, 4 and 5 give 0 and code 1 gives 1.
- R5: Positive and negative zero compare equal, and neither one is less than the other.
- R6: When `cmp_valid` is low, both flags keep their value.
- R7: Operator codes 6 and 7 give 0.
- R8: With `sel_uniform` low, `take_branch` is computed from two terms, tx = (`flag_x` == `ref_x`) and ty = (`flag_y` == `ref_y`). The `mode` field selects the result: 0 gives tx OR ty, 1 gives tx AND ty, 2 gives tx alone, 3 gives ty alone.
- R9: With `sel_uniform` high, `take_branch` equals uniform entry `uni_idx` XOR `uni_invert`, and the flags and references have no effect.
- R10: A uniform write (`uni_we` high) stores `uni_wdata` into entry `uni_widx`. The new value is visible from the next clock edge, and all other entries keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare strobe |
| op_x | input | 3 | X-lane operator code |
| op_y | input | 3 | Y-lane operator code |
| a_x | input | 32 | First operand, X lane |
| b_x | input | 32 | Second operand, X lane |
| a_y | input | 32 | First operand, Y lane |
| b_y | input | 32 | Second operand, Y lane |
| uni_we | input | 1 | Uniform write enable |
| uni_widx | input | 4 | Uniform write index |
| uni_wdata | input | 1 | Uniform write value |
| sel_uniform | input | 1 | Pick the uniform source instead of the flag source |
| uni_idx | input | 4 | Uniform entry to test |
| uni_invert | input | 1 | Invert the uniform sense |
| mode | input | 2 | Flag combine mode |
| ref_x | input | 1 | Reference bit for flag_x |
| ref_y | input | 1 | Reference bit for flag_y |
| flag_x | output | 1 | X-lane condition flag |
| flag_y | output | 1 | Y-lane condition flag |
| take_branch | output | 1 | Evaluated branch condition |

## Verification
The bench targets several corner cases, each of which a specific bug would break:

- **Operand swap.** Greater-than and greater-or-equal are built by swapping operands. Swapping them wrongly inverts results on unequal inputs.
- **NaN.** Comparing through integer order instead of float rules would let NaN satisfy ordered tests, or report NaN as equal to NaN.
- **Signed zero.** A plain bit comparison would call +0 and -0 different and order -0 below +0.
- **Negative values.** Magnitude ordering is reversed when both operands are negative.
- **Lane mixing.** The Y lane uses an operator different from X, which catches a design that routes one operator to both lanes.
- **Combine modes.** Every mode is exercised with flags and references that disagree in one term, so a swapped mode or a misplaced reference shows up.
- **Uniform path.** Uniform tests cover inversion and cases where the flags would give the opposite answer, which catches a source mux that leaks.

// File: rtl/vcmp_cond_unit.sv
module vcmp_cond_unit #(
  parameter int UNI_COUNT = 16,
  localparam int UW = $clog2(UNI_COUNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_valid,
  input  logic [2:0]    op_x,
  input  logic [2:0]    op_y,
  input  logic [31:0]   a_x,
  input  logic [31:0]   b_x,
  input  logic [31:0]   a_y,
  input  logic [31:0]   b_y,
  input  logic          uni_we,
  input  logic [UW-1:0] uni_widx,
  input  logic          uni_wdata,
  input  logic          sel_uniform,
  input  logic [UW-1:0] uni_idx,
  input  logic          uni_invert,
  input  logic [1:0]    mode,
  input  logic          ref_x,
  input  logic          ref_y,
  output logic          flag_x,
  output logic          flag_y,
  output logic          take_branch
);

  function automatic logic is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  function automatic logic f_eq(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    if (a[30:0] == 31'd0 && b[30:0] == 31'd0) return 1'b1;
    return a == b;
  endfunction

  function automatic logic f_lt(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    if (a[30:0] == 31'd0 && b[30:0] == 31'd0) return 1'b0;
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction

  function automatic logic lane_cmp(input logic [2:0] op, input logic [31:0] a,
                                    input logic [31:0] b);
    case (op)
      3'd0:    return f_eq(a, b);
      3'd1:    return !f_eq(a, b);
      3'd2:    return f_lt(a, b);
      3'd3:    return f_lt(a, b) || f_eq(a, b);
      3'd4:    return f_lt(b, a);
      3'd5:    return f_lt(b, a) || f_eq(b, a);
      default: return 1'b0;
    endcase
  endfunction

  logic [UNI_COUNT-1:0] uni_bank;
  logic                 res_x, res_y, tx, ty, flag_cond;

  assign res_x = lane_cmp(op_x, a_x, b_x);
  assign res_y = lane_cmp(op_y, a_y, b_y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_x <= 1'b0;
      flag_y <= 1'b0;
    end else if (cmp_valid) begin
      flag_x <= res_x;
      flag_y <= res_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uni_bank <= '0;
    else if (uni_we) uni_bank[uni_widx] <= uni_wdata;
  end

  assign tx = (flag_x == ref_x);
  assign ty = (flag_y == ref_y);

  always_comb begin
    case (mode)
      2'd0:    flag_cond = tx | ty;
      2'd1:    flag_cond = tx & ty;
      2'd2:    flag_cond = tx;
      default: flag_cond = ty;
    endcase
  end

  assign take_branch = sel_uniform ? (uni_bank[uni_idx] ^ uni_invert) : flag_cond;

endmodule

// File: rtl/vcmp_cond_unit_checker.sv
module vcmp_cond_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmp_valid,
  input logic [2:0]  op_x,
  input logic [2:0]  op_y,
  input logic [31:0] a_x,
  input logic [31:0] b_x,
  input logic        sel_uniform,
  input logic [1:0]  mode,
  input logic        ref_x,
  input logic        ref_y,
  input logic        flag_x,
  input logic        flag_y,
  input logic        take_branch
);
  logic ax_nan;
  assign ax_nan = (a_x[30:23] == 8'hFF) && (a_x[22:0] != 23'd0);

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(flag_x) && $stable(flag_y));

  assert_nan_eq_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && ax_nan && op_x == 3'd0) |=> !flag_x);

  assert_nan_ne_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && ax_nan && op_x == 3'd1) |=> flag_x);

  assert_bad_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && op_x[2:1] == 2'b11 && op_y[2:1] == 2'b11) |=> !flag_x && !flag_y);

  assert_self_eq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !ax_nan && op_x == 3'd0 && a_x == b_x) |=> flag_x);

  assert_mode_x_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_uniform && mode == 2'd2) |-> take_branch == (flag_x == ref_x));

  assert_mode_y_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_uniform && mode == 2'd3) |-> take_branch == (flag_y == ref_y));
endmodule

bind vcmp_cond_unit vcmp_cond_unit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .op_x(op_x), .op_y(op_y),
  .a_x(a_x), .b_x(b_x), .sel_uniform(sel_uniform), .mode(mode), .ref_x(ref_x),
  .ref_y(ref_y), .flag_x(flag_x), .flag_y(flag_y), .take_branch(take_branch)
);

// File: tb/vcmp_cond_unit_bench.sv
module vcmp_cond_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmp_valid = 0, uni_we = 0, uni_wdata = 0, sel_uniform = 0, uni_invert = 0;
  logic ref_x = 0, ref_y = 0;
  logic [2:0] op_x = 0, op_y = 0;
  logic [31:0] a_x = 0, b_x = 0, a_y = 0, b_y = 0;
  logic [3:0] uni_widx = 0, uni_idx = 0;
  logic [1:0] mode = 0;
  logic flag_x, flag_y, take_branch;
  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  vcmp_cond_unit u_vcmp_cond_unit (.*);

  localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000, N1 = 32'hBF800000,
    N2 = 32'hC0000000, PZ = 32'h0, NZ = 32'h80000000, QN = 32'h7FC00000, PI = 32'h7F800000;

  typedef struct packed {
    logic [2:0] ox; logic [31:0] ax, bx;
    logic [2:0] oy; logic [31:0] ay, by;
    logic ex, ey;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    {3'd0, P1, P1, 3'd1, P1, P2, 1'b1, 1'b1},  // R2 R3 eq / ne
    {3'd2, P1, P2, 3'd3, P2, P2, 1'b1, 1'b1},  // R2 R3 lt / le
    {3'd4, P1, P2, 3'd5, N1, N2, 1'b0, 1'b1},  // R2 R3 gt / ge
    {3'd2, N2, N1, 3'd4, N1, P1, 1'b1, 1'b0},  // R2 R3 negatives
    {3'd0, PZ, NZ, 3'd2, NZ, PZ, 1'b1, 1'b0},  // R5 signed zero
    {3'd0, QN, QN, 3'd1, QN, P1, 1'b0, 1'b1},  // R4 NaN eq / ne
    {3'd5, QN, P1, 3'd3, P1, QN, 1'b0, 1'b0},  // R4 NaN ge / le
    {3'd6, P1, P1, 3'd7, P1, P1, 1'b0, 1'b0},  // R7 unused codes
    {3'd3, P1, PI, 3'd4, PI, P2, 1'b1, 1'b1},  // R2 R3 infinity
    {3'd1, P2, P2, 3'd0, P1, P2, 1'b0, 1'b0}   // R2 R3 false results
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_cmp(input logic [2:0] ox, input logic [31:0] ax, bx,
                        input logic [2:0] oy, input logic [31:0] ay, by);
    @(negedge clk);
    op_x = ox; a_x = ax; b_x = bx; op_y = oy; a_y = ay; b_y = by; cmp_valid = 1;
    @(negedge clk);
    cmp_valid = 0;
  endtask

  task automatic uni_write(input logic [3:0] idx, input logic v);
    @(negedge clk);
    uni_widx = idx; uni_wdata = v; uni_we = 1;
    @(negedge clk);
    uni_we = 0;
  endtask

  task automatic chk_take(input string tag, input logic exp);
    #1 check(tag, take_branch, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    check("R1 flag_x reset", flag_x, 1'b0);
    check("R1 flag_y reset", flag_y, 1'b0);
    sel_uniform = 1; uni_idx = 4'd9;
    chk_take("R1 uniform reset", 1'b0);
    sel_uniform = 0;
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      do_cmp(TBL[i].ox, TBL[i].ax, TBL[i].bx, TBL[i].oy, TBL[i].ay, TBL[i].by);
      check($sformatf("R2 vec%0d flag_x", i), flag_x, TBL[i].ex);
      check($sformatf("R3 vec%0d flag_y", i), flag_y, TBL[i].ey);
    end

    // R6 hold: flags 1/0, then change operands without strobe
    do_cmp(3'd0, P1, P1, 3'd1, P1, P1);
    @(negedge clk);
    op_x = 3'd1; op_y = 3'd0; a_y = P2; b_y = P2;
    @(negedge clk); @(negedge clk);
    check("R6 flag_x held", flag_x, 1'b1);
    check("R6 flag_y held", flag_y, 1'b0);

    // R8 modes with flag_x=1, flag_y=0
    ref_x = 1; ref_y = 1;
    mode = 2'd0; chk_take("R8 or", 1'b1);
    mode = 2'd1; chk_take("R8 and", 1'b0);
    ref_x = 0;
    mode = 2'd2; chk_take("R8 x only", 1'b0);
    ref_y = 0;
    mode = 2'd3; chk_take("R8 y only", 1'b1);
    mode = 2'd1; ref_x = 1; chk_take("R8 and both", 1'b1);

    // R10 uniform write
    uni_write(4'd5, 1'b1);
    sel_uniform = 1; uni_invert = 0;
    uni_idx = 4'd5; chk_take("R10 entry written", 1'b1);
    uni_idx = 4'd4; chk_take("R10 neighbour unchanged", 1'b0);
    uni_idx = 4'd6; chk_take("R10 neighbour unchanged", 1'b0);
    // R9 source and inversion; flag path would give 1 here
    uni_idx = 4'd4; chk_take("R9 flags ignored", 1'b0);
    uni_invert = 1;
    uni_idx = 4'd5; chk_take("R9 inverted set", 1'b0);
    uni_idx = 4'd4; chk_take("R9 inverted clear", 1'b1);
    uni_write(4'd5, 1'b0);
    uni_invert = 0; uni_idx = 4'd5;
    chk_take("R10 entry cleared", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule